// File: doc/BRIEF.md
# Burst-Capable Instruction Fetch Bus Controller

This block is the bus master for a processor whose address and data share one 32-bit multiplexed bus. It accepts one request at a time from the core: an instruction fetch, a data read or a data write. It then runs the bus cycle. Every cycle opens with an address phase: the word address is driven on the shared wires and a one-clock latch strobe is given. A read or write that is not a burst ends after four clocks.

Instruction fetches can be streamed. When a fetch has further words left in its aligned 16-byte block, the controller raises a burst request. If memory answers with a burst acknowledge at the moment the first word is taken, the following words arrive every two clocks with no new address phase. The stream stops after the last word of the 16-byte block. Memory can stretch any data phase with a wait input. Each fetched word goes to the fetch queue as a one-clock pulse together with its word address.

The state machine has seven states. IDLE waits for a request. ADDR is the address phase. SETUP is the turnaround clock. DATA is the first data phase. BGAP is the address-free gap between burst words. BDATA is a burst data phase. DONE is the closing clock.

Its transitions are:
- IDLE→ADDR when a request is taken (load).
- ADDR→SETUP.
- SETUP→DATA.
- DATA→DATA while wait is high (stall).
- DATA→BGAP when a word is taken with the burst requested and acknowledged (grant).
- DATA→DONE on any other take (single).
- BGAP→BDATA.
- BDATA→BDATA while wait is high (stall).
- BDATA→BGAP when the taken word is not last in its block (chain).
- BDATA→DONE when the taken word is last in its block (boundary).
- DONE→IDLE.

Top module: `burst_fetch_busctl`

## Requirements
- R1: After reset the controller is idle. `req_ready` is 1. `ale`, `ad_oe`, `dstb`, `bus_rd`, `bus_wr`, `burst_req`, `fetch_valid` and `data_valid` are all 0.
- R2: The clock after a request is taken (`req_valid` and `req_ready` both high at an edge) is the address phase. In that clock `ale` is 1 for exactly one clock, `ad_oe` is 1, and `ad_out` equals `{req_word, 2'b00}`. `ale` is never high in any other clock of the cycle.
- R3: With no wait states, a read or write cycle holds `req_ready` low for exactly four clocks. For a write (`req_kind` 2'b10), the write data is on `ad_out` with `ad_oe` high while `dstb` marks the data phase. A data read is `req_kind` 2'b01.
- R4: Data reads and writes never assert `burst_req`.
- R5: A fetch (`req_kind` 2'b00) asserts `burst_req` in its address phase exactly when the word index within the 16-byte block (`req_word[1:0]`) is not 3.
- R6: `burst_ack` is sampled only on the edge at which the first word is taken. If it is low there, the fetch ends as a single four-clock transfer plus any waits.
- R7: In a granted burst, each word after the first is taken two clocks after the previous one, with no `ale`. A burst of n words takes 2 + 2n clocks without waits.
- R8: A burst ends after the word whose index in the block is 3. A burst starting at index k therefore delivers 4 − k words.
- R9: When `wait_in` is high at the end of a data phase (`dstb` high), that phase repeats and no word is taken. This holds for burst data phases too. Each wait clock adds one clock to the cycle.
- R10: Each word taken by a fetch gives a one-clock `fetch_valid` pulse in the following clock. The pulse carries the word in `rdata` and its word address in `fetch_word`. A taken data-read word gives a one-clock `data_valid` pulse in the same way.
- R11: While a cycle is in progress, `req_ready` is low and the request inputs are ignored. A request held high is taken on the edge after the closing clock, so back-to-back cycles start their address phases five clocks apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core has a request pending |
| req_kind | input | 2 | 00 fetch, 01 data read, 10 data write |
| req_word | input | 30 | Word address of the request |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Controller idle, request taken at this edge if valid |
| ale | output | 1 | Address latch strobe, address phase only |
| ad_out | output | 32 | Multiplexed address/data bus, outgoing |
| ad_oe | output | 1 | Output enable for `ad_out` |
| ad_in | input | 32 | Multiplexed bus, incoming data |
| dstb | output | 1 | Data phase strobe |
| bus_rd | output | 1 | Read cycle in progress |
| bus_wr | output | 1 | Write cycle in progress |
| wait_in | input | 1 | Memory wait, sampled at end of each data phase |
| burst_req | output | 1 | Burst requested, more words remain in the block |
| burst_ack | input | 1 | Memory grants the burst |
| fetch_valid | output | 1 | One-clock pulse for each fetched word |
| fetch_word | output | 30 | Word address of the fetched word |
| data_valid | output | 1 | One-clock pulse for a data-read word |
| rdata | output | 32 | Captured read word |

## Verification
The sensitive coincidence is between the wait extension and the burst-grant decision. Both act on the same edge at the end of the first data phase. The grant must be judged at the edge where the word is actually taken, not at an earlier edge where a wait held it back.

The bench provokes this with a fetch that is eligible for a burst. It inserts one wait clock and drives `burst_ack` high only during that wait clock. A correct controller delivers exactly one word in five clocks. A controller that latches the grant early streams the whole block.

A second collision pairs the boundary stop with a granted acknowledge on a block's last word. There the bench expects `burst_req` low from the address phase and a single transfer.

// File: rtl/busctl_pkg.sv
package busctl_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_SETUP,
        ST_DATA,
        ST_BGAP,
        ST_BDATA,
        ST_DONE
    } bus_state_e;

    typedef enum logic [1:0] {
        K_FETCH = 2'b00,
        K_READ  = 2'b01,
        K_WRITE = 2'b10,
        K_RSVD  = 2'b11
    } req_kind_e;

endpackage

// File: rtl/busctl_fsm.sv
module busctl_fsm
    import busctl_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  req_kind_e cyc_kind,
    input  logic      last_beat,
    input  logic      wait_in,
    input  logic      burst_ack,
    output logic      load,
    output logic      take,
    output logic      drive_addr,
    output logic      req_ready,
    output logic      ale,
    output logic      ad_oe,
    output logic      dstb,
    output logic      bus_rd,
    output logic      bus_wr,
    output logic      burst_req
);

    bus_state_e state, nxt;
    logic       want_burst;
    logic       is_write;

    assign want_burst = (cyc_kind == K_FETCH) && !last_beat;
    assign is_write   = (cyc_kind == K_WRITE);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // transitions
    always_comb begin
        nxt  = state;
        load = 1'b0;
        take = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (req_valid) begin
                    load = 1'b1;
                    nxt  = ST_ADDR;
                end
            end
            ST_ADDR:  nxt = ST_SETUP;
            ST_SETUP: nxt = ST_DATA;
            ST_DATA: begin
                if (!wait_in) begin
                    take = 1'b1;
                    nxt  = (want_burst && burst_ack) ? ST_BGAP : ST_DONE;
                end
            end
            ST_BGAP:  nxt = ST_BDATA;
            ST_BDATA: begin
                if (!wait_in) begin
                    take = 1'b1;
                    nxt  = last_beat ? ST_DONE : ST_BGAP;
                end
            end
            ST_DONE:  nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready  = (state == ST_IDLE);
        ale        = (state == ST_ADDR);
        drive_addr = (state == ST_ADDR);
        dstb       = (state == ST_DATA) || (state == ST_BDATA);
        bus_wr     = is_write && ((state == ST_SETUP) || (state == ST_DATA));
        bus_rd     = !is_write && ((state == ST_SETUP) || (state == ST_DATA) ||
                                   (state == ST_BGAP)  || (state == ST_BDATA));
        ad_oe      = (state == ST_ADDR) || bus_wr;
        burst_req  = want_burst && (state != ST_IDLE) && (state != ST_DONE);
    end

    a_r2_ale_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> !ale);

    a_r4_write_no_burst: assert property (@(posedge clk) disable iff (!rst_n)
        bus_wr |-> !burst_req);

    a_r11_ready_drop_opens_addr: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(req_ready) |-> ale);

endmodule

// File: rtl/busctl_dpath.sv
module busctl_dpath
    import busctl_pkg::*;
#(
    parameter int BUS_W     = 32,
    parameter int BYTE_BITS = 2,
    parameter int BEAT_BITS = 2,
    localparam int WORD_W   = BUS_W - BYTE_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              take,
    input  logic              drive_addr,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_word,
    input  logic [BUS_W-1:0]  req_wdata,
    input  logic [BUS_W-1:0]  ad_in,
    output req_kind_e         cyc_kind,
    output logic              last_beat,
    output logic [BUS_W-1:0]  ad_out,
    output logic              fetch_valid,
    output logic [WORD_W-1:0] fetch_word,
    output logic              data_valid,
    output logic [BUS_W-1:0]  rdata
);

    logic [WORD_W-1:0] cur_word;
    logic [BUS_W-1:0]  wdata_q;
    logic [BEAT_BITS-1:0] beat_nxt;

    assign last_beat = &cur_word[BEAT_BITS-1:0];
    assign beat_nxt  = BEAT_BITS'(cur_word[BEAT_BITS-1:0] + 1'b1);
    assign ad_out    = drive_addr ? {cur_word, {BYTE_BITS{1'b0}}} : wdata_q;

    // cycle context: address counter wraps inside the block
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_word <= '0;
            cyc_kind <= K_FETCH;
            wdata_q  <= '0;
        end else if (load) begin
            cur_word <= req_word;
            cyc_kind <= req_kind_e'(req_kind);
            wdata_q  <= req_wdata;
        end else if (take) begin
            cur_word[BEAT_BITS-1:0] <= beat_nxt;
        end
    end

    // per-word handoff
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fetch_valid <= 1'b0;
            data_valid  <= 1'b0;
            fetch_word  <= '0;
            rdata       <= '0;
        end else begin
            fetch_valid <= take && (cyc_kind == K_FETCH);
            data_valid  <= take && (cyc_kind != K_FETCH) && (cyc_kind != K_WRITE);
            if (take && (cyc_kind != K_WRITE)) begin
                rdata      <= ad_in;
                fetch_word <= cur_word;
            end
        end
    end

    a_r10_one_pulse_per_take: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || data_valid) |-> !(fetch_valid && data_valid));

endmodule

// File: rtl/burst_fetch_busctl.sv
module burst_fetch_busctl
    import busctl_pkg::*;
#(
    parameter int BUS_W       = 32,
    parameter int BLOCK_BYTES = 16,
    localparam int BYTE_BITS  = $clog2(BUS_W / 8),
    localparam int WORD_W     = BUS_W - BYTE_BITS,
    localparam int BEAT_BITS  = $clog2(BLOCK_BYTES) - BYTE_BITS
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [WORD_W-1:0] req_word,
    input  logic [BUS_W-1:0]  req_wdata,
    output logic              req_ready,
    output logic              ale,
    output logic [BUS_W-1:0]  ad_out,
    output logic              ad_oe,
    input  logic [BUS_W-1:0]  ad_in,
    output logic              dstb,
    output logic              bus_rd,
    output logic              bus_wr,
    input  logic              wait_in,
    output logic              burst_req,
    input  logic              burst_ack,
    output logic              fetch_valid,
    output logic [WORD_W-1:0] fetch_word,
    output logic              data_valid,
    output logic [BUS_W-1:0]  rdata
);

    req_kind_e cyc_kind;
    logic      last_beat;
    logic      load;
    logic      take;
    logic      drive_addr;

    busctl_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .cyc_kind   (cyc_kind),
        .last_beat  (last_beat),
        .wait_in    (wait_in),
        .burst_ack  (burst_ack),
        .load       (load),
        .take       (take),
        .drive_addr (drive_addr),
        .req_ready  (req_ready),
        .ale        (ale),
        .ad_oe      (ad_oe),
        .dstb       (dstb),
        .bus_rd     (bus_rd),
        .bus_wr     (bus_wr),
        .burst_req  (burst_req)
    );

    busctl_dpath #(
        .BUS_W     (BUS_W),
        .BYTE_BITS (BYTE_BITS),
        .BEAT_BITS (BEAT_BITS)
    ) u_dpath (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (load),
        .take        (take),
        .drive_addr  (drive_addr),
        .req_kind    (req_kind),
        .req_word    (req_word),
        .req_wdata   (req_wdata),
        .ad_in       (ad_in),
        .cyc_kind    (cyc_kind),
        .last_beat   (last_beat),
        .ad_out      (ad_out),
        .fetch_valid (fetch_valid),
        .fetch_word  (fetch_word),
        .data_valid  (data_valid),
        .rdata       (rdata)
    );

    a_r9_no_take_under_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid || data_valid) |-> ($past(dstb) && !$past(wait_in)));

    a_r10_fetch_pulse_single: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_valid |=> !fetch_valid);

    a_r7_burst_stride_no_ale: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && $past(fetch_valid, 2)) |->
            ((fetch_word == WORD_W'($past(fetch_word, 2) + 1'b1)) && !$past(ale)));

    a_r8_stop_at_block_end: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_valid && (&fetch_word[BEAT_BITS-1:0])) |-> !burst_req);

endmodule

// File: tb/tb_burst_fetch_busctl.sv
module tb_burst_fetch_busctl;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'b00;
    logic [29:0] req_word = '0;
    logic [31:0] req_wdata = '0;
    logic        req_ready, ale, ad_oe, dstb, bus_rd, bus_wr, burst_req;
    logic        fetch_valid, data_valid;
    logic [31:0] ad_out, rdata;
    logic [29:0] fetch_word;
    logic [31:0] ad_in;
    logic        wait_in = 1'b0;
    logic        burst_ack = 1'b0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // memory model configuration
    int          wait_n = 0;
    int          wcnt = 0;
    logic        ack_cfg = 1'b0;
    logic        ack_in_wait = 1'b0;
    logic [29:0] ptr = '0;
    logic [31:0] wr_seen = '0;

    // kind[36:35] ack[34] waits[33:32] byte address[31:0]
    localparam logic [36:0] VEC [NV] = '{
        {2'b00, 1'b1, 2'd0, 32'h0000_1000},
        {2'b00, 1'b1, 2'd0, 32'h0000_1008},
        {2'b00, 1'b1, 2'd0, 32'h0000_100C},
        {2'b00, 1'b0, 2'd0, 32'h0000_2004},
        {2'b00, 1'b1, 2'd1, 32'h0000_3004},
        {2'b01, 1'b1, 2'd0, 32'h0000_4000},
        {2'b10, 1'b1, 2'd0, 32'h0000_5000},
        {2'b01, 1'b0, 2'd2, 32'h0000_6008},
        {2'b00, 1'b0, 2'd1, 32'h0000_7000},
        {2'b10, 1'b0, 2'd1, 32'h0000_8004}
    };

    burst_fetch_busctl dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_kind(req_kind), .req_word(req_word),
        .req_wdata(req_wdata), .req_ready(req_ready),
        .ale(ale), .ad_out(ad_out), .ad_oe(ad_oe), .ad_in(ad_in),
        .dstb(dstb), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .wait_in(wait_in), .burst_req(burst_req), .burst_ack(burst_ack),
        .fetch_valid(fetch_valid), .fetch_word(fetch_word),
        .data_valid(data_valid), .rdata(rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] pat(input logic [29:0] w);
        return {w[13:0], w[29:12]} ^ 32'hC3A5_0F1E;
    endfunction

    assign ad_in = pat(ptr);

    // memory side: address latch, pointer advance, write capture
    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (ale) ptr <= ad_out[31:2];
        else if (fetch_valid || data_valid) ptr <= ptr + 30'd1;
        if (bus_wr && dstb && !wait_in && ad_oe) wr_seen <= ad_out;
        if (dstb) wcnt <= wait_in ? wcnt + 1 : 0;
    end

    always @(negedge clk) begin
        wait_in   = dstb && (wcnt < wait_n);
        burst_ack = ack_in_wait ? wait_in : ack_cfg;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        if (cyc > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%h expected=%h", cyc, 32'd100000);
            finish_run();
        end
    end

    // one bus cycle, judged at the ports
    task automatic run_cycle(input logic [1:0] kind, input logic [31:0] addr,
                             input logic ack, input int wn, input logic ackw);
        logic [29:0] w0;
        int exp_n, exp_len, len, got, ales;
        logic exp_breq;
        w0       = addr[31:2];
        exp_breq = (kind == 2'b00) && (addr[3:2] != 2'b11);
        exp_n    = (exp_breq && ack && !ackw) ? 4 - int'(addr[3:2]) : 1;
        exp_len  = 2 + 2*exp_n + exp_n*wn;
        wait_n = wn; ack_cfg = ack; ack_in_wait = ackw;
        @(negedge clk);
        req_valid = 1'b1; req_kind = kind; req_word = w0;
        req_wdata = ~addr ^ 32'h1357_9BDF;
        @(negedge clk);
        req_valid = 1'b0;
        req_word  = ~w0;
        check(ale && ad_oe, "R2 ale/oe in address phase", {30'd0, ale, ad_oe}, 32'd3);
        check(ad_out == {w0, 2'b00}, "R2 address on bus", ad_out, {w0, 2'b00});
        check(burst_req == exp_breq, (kind == 2'b00) ? "R5 burst_req" : "R4 burst_req",
              {31'd0, burst_req}, {31'd0, exp_breq});
        len = 0; got = 0; ales = 0;
        while (!req_ready && cyc < 100000) begin
            len++;
            if (ale) ales++;
            if (kind != 2'b00 && burst_req)
                check(1'b0, "R4 burst_req on data cycle", 32'd1, 32'd0);
            if (fetch_valid) begin
                check(fetch_word == w0 + 30'(got), "R10 fetch_word",
                      {2'b0, fetch_word}, {2'b0, w0 + 30'(got)});
                check(rdata == pat(w0 + 30'(got)), "R10 fetch data",
                      rdata, pat(w0 + 30'(got)));
                got++;
            end
            if (data_valid) begin
                check(rdata == pat(w0), "R10 data read word", rdata, pat(w0));
                got++;
            end
            @(negedge clk);
        end
        check(len == exp_len, (wn > 0) ? "R9 cycle length with waits" :
              (exp_n > 1) ? "R7 burst length" : "R3 single length",
              len, exp_len);
        check(ales == 1, "R2 single ale per cycle", ales, 32'd1);
        if (kind == 2'b10) begin
            check(got == 0, "R10 no pulse on write", got, 32'd0);
            check(wr_seen == (~addr ^ 32'h1357_9BDF), "R3 write data on bus",
                  wr_seen, ~addr ^ 32'h1357_9BDF);
        end else begin
            check(got == exp_n, (exp_n < 4 && exp_breq && ack) ? "R8 words to boundary" :
                  (!ack && kind == 2'b00) ? "R6 no ack single word" : "R10 word count",
                  got, exp_n);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check(req_ready == 1'b1, "R1 req_ready", {31'd0, req_ready}, 32'd1);
        check({ale, ad_oe, dstb, bus_rd, bus_wr, burst_req, fetch_valid, data_valid} == 8'd0,
              "R1 idle outputs",
              {24'd0, ale, ad_oe, dstb, bus_rd, bus_wr, burst_req, fetch_valid, data_valid},
              32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check(req_ready && !ale, "R1 idle after release", {30'd0, req_ready, ale}, 32'd2);

        // vector table
        for (int i = 0; i < NV; i++) begin
            logic [36:0] v;
            v = VEC[i];
            run_cycle(v[36:35], v[31:0], v[34], int'(v[33:32]), 1'b0);
        end

        // R6/R9: grant seen only during the wait clock
        run_cycle(2'b00, 32'h0000_9000, 1'b0, 1, 1'b1);
        // R8: ack on last word of block, no burst
        run_cycle(2'b00, 32'h0000_A00C, 1'b1, 0, 1'b0);

        // R11: held request while busy, back-to-back spacing
        begin
            int gap;
            wait_n = 0; ack_cfg = 1'b0; ack_in_wait = 1'b0;
            @(negedge clk);
            req_valid = 1'b1; req_kind = 2'b01; req_word = 30'h0000_0B00;
            @(negedge clk);
            check(ale == 1'b1, "R11 first address phase", {31'd0, ale}, 32'd1);
            req_kind = 2'b10; req_word = 30'h0000_0C01; req_wdata = 32'hDEAD_0011;
            gap = 0;
            do begin
                @(negedge clk);
                gap++;
                if (data_valid)
                    check(rdata == pat(30'h0000_0B00), "R11 first cycle unaffected",
                          rdata, pat(30'h0000_0B00));
                if (gap < 5)
                    check(!ale, "R11 no ale while busy", {31'd0, ale}, 32'd0);
            end while (!ale && gap < 20);
            check(gap == 5, "R11 back-to-back spacing", gap, 32'd5);
            check(ad_out == {30'h0000_0C01, 2'b00}, "R11 second address",
                  ad_out, {30'h0000_0C01, 2'b00});
            req_valid = 1'b0;
            while (!req_ready) @(negedge clk);
            check(wr_seen == 32'hDEAD_0011, "R3 held write data", wr_seen, 32'hDEAD_0011);
        end

        finish_run();
    end

endmodule